// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus cycles of a small 8-bit processor core. The core posts one request at a time: a memory or I/O read or write, or an instruction fetch from an internal program counter. For each request the controller places a 16-bit address on the pins and announces it with an address latch enable pulse. The low address byte shares eight pins with the data bus, so outside logic latches it while that pulse is high. The controller then drives a read or write strobe. It adds whole-clock wait states for as long as the ready input is low, and it hands read data back to the core with a done pulse.

Between cycles the controller can give the bus to an external master. A hold request is taken at a cycle boundary. The controller then floats the address, data and control pins and raises a hold acknowledge. It takes the pins back once hold is removed. An active-low reset input floats every pin, clears the program counter and raises a reset output for other devices. Pin output enables are separate ports, so the floating state can be seen directly.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While `rst_n_i` is low, and until the synchronized release completes, `rst_out_o` is 1 and `ad_oe_o`, `a_hi_oe_o`, `ctl_oe_o` and `hlda_o` are 0. Entering reset also clears the program counter, so the first fetch after any reset uses address 0x0000.
- R2: Every bus cycle begins with one T1 clock. In T1, `ale_o` is 1 for exactly that clock, `ad_o` carries the low address byte with `ad_oe_o`=1, `a_hi_o` carries the high byte, and both strobes are high. A strobe goes low on the very next clock.
- R3: `iom_o` is 1 for an I/O cycle and 0 for a memory or fetch cycle. It and `a_hi_o` keep the same value from T1 until the strobe is released.
- R4: In a read, `rd_n_o` is low from T2 through T3 with `ad_oe_o`=0. The value on `ad_i` at the end of T3 appears on `rdata_o` when `done_o` pulses for one clock, in the clock after T3.
- R5: In a write, `wr_n_o` is low from T2 through T3 while `ad_o` carries the write data with `ad_oe_o`=1. `done_o` then pulses once.
- R6: Each low sample of `ready_i` in T2 or in a wait state adds one wait clock. With N such samples the strobe stays low for exactly 2+N clocks.
- R7: `req_ack_o` is 1 only in an idle clock with `req_i` high and `hold_i` low. Each acknowledge starts exactly one bus cycle and lasts one clock.
- R8: A request with `req_fetch_i`=1 runs a memory read at the program counter and ignores `req_addr_i`, `req_wr_i` and `req_io_i`. The counter then advances by one.
- R9: `hold_i` is taken only at a cycle boundary. A cycle already under way completes first. One clock later `hlda_o` is 1, every output enable is 0, and no request is acknowledged.
- R10: `hlda_o` falls one clock after `hold_i` is seen low. In that clock `ctl_oe_o` and `a_hi_oe_o` are 1, before any new T1.
- R11: `rd_n_o` and `wr_n_o` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low reset, asserts asynchronously |
| rst_out_o | output | 1 | High while the controller is in reset |
| req_i | input | 1 | Core request valid, held until acknowledged |
| req_fetch_i | input | 1 | Request is an instruction fetch at the program counter |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| req_ack_o | output | 1 | Request accepted this clock |
| done_o | output | 1 | One-clock pulse when a cycle completes |
| rdata_o | output | 8 | Read data, valid with done_o |
| ad_o | output | 8 | Shared low address / data pins, out direction |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 8 | Shared pins, in direction |
| a_hi_o | output | 8 | High address byte |
| a_hi_oe_o | output | 1 | Drive enable for a_hi_o |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| iom_o | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| ctl_oe_o | output | 1 | Drive enable for ale_o, rd_n_o, wr_n_o, iom_o |
| ready_i | input | 1 | Slow device ready; low inserts wait states |
| hold_i | input | 1 | External master requests the bus |
| hlda_o | output | 1 | Bus released to the external master |

## Verification
Cycles are tried with every mix of fetch, memory and I/O space and of read and write, each with its own address and data. This separates a wrong space flag or direction from a wrong address byte on the shared pins. Wait counts of 0, 1, 2, 3 and 4 show whether the strobe width follows the ready input clock for clock and not a fixed length. A hold raised while idle, a hold raised during a stretched cycle, and a request left pending across a hold show whether hold is taken only at boundaries. A reset in the middle of a cycle, followed by a fetch, shows that the pins float at once and that the program counter restarts at zero.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   typedef enum logic [2:0] {
      ST_RST  = 3'd0,
      ST_IDLE = 3'd1,
      ST_T1   = 3'd2,
      ST_T2   = 3'd3,
      ST_TW   = 3'd4,
      ST_T3   = 3'd5,
      ST_HOLD = 3'd6
   } mbc_state_e;

endpackage

// File: rtl/mbc_rst_sync.sv
module mbc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   output logic rst_n_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mbc_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   // assert at once, release after STAGES clocks
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbc_fetch_ptr.sv
module mbc_fetch_ptr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] pc_o
);
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)    pc_o <= '0;
      else if (step_i) pc_o <= pc_o + 1'b1;
   end

   // R8
   pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      step_i |=> (pc_o == $past(pc_o) + 1'b1));
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
   import mbc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              req_i,
   input  logic              req_fetch_i,
   input  logic              req_wr_i,
   input  logic              req_io_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              ready_i,
   input  logic              hold_i,
   input  logic [DATA_W-1:0] ad_i,
   output mbc_state_e        state_o,
   output logic [ADDR_W-1:0] op_addr_o,
   output logic              op_wr_o,
   output logic              op_io_o,
   output logic [DATA_W-1:0] op_wdata_o,
   output logic              req_ack_o,
   output logic              fetch_step_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o
);
   mbc_state_e st_q, st_d;
   logic       take;

   assign take         = (st_q == ST_IDLE) && req_i && !hold_i;
   assign req_ack_o    = take;
   assign fetch_step_o = take && req_fetch_i;
   assign state_o      = st_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RST:  st_d = ST_IDLE;
         ST_IDLE: begin
            if (hold_i)     st_d = ST_HOLD;
            else if (req_i) st_d = ST_T1;
         end
         ST_T1:   st_d = ST_T2;
         ST_T2,
         ST_TW:   st_d = ready_i ? ST_T3 : ST_TW;
         ST_T3:   st_d = ST_IDLE;
         ST_HOLD: if (!hold_i) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         st_q       <= ST_RST;
         op_addr_o  <= '0;
         op_wr_o    <= 1'b0;
         op_io_o    <= 1'b0;
         op_wdata_o <= '0;
         done_o     <= 1'b0;
         rdata_o    <= '0;
      end else begin
         st_q   <= st_d;
         done_o <= (st_q == ST_T3);
         if (take) begin
            op_addr_o  <= req_fetch_i ? pc_i : req_addr_i;
            op_wr_o    <= req_wr_i && !req_fetch_i;
            op_io_o    <= req_io_i && !req_fetch_i;
            op_wdata_o <= req_wdata_i;
         end
         if ((st_q == ST_T3) && !op_wr_o) rdata_o <= ad_i;
      end
   end

   // R6
   wait_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((st_q == ST_T2 || st_q == ST_TW) && !ready_i) |=> (st_q == ST_TW));

   // R4
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_o |=> !done_o);

   // R7
   one_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      req_ack_o |=> (!req_ack_o && st_q == ST_T1));
endmodule

// File: rtl/mbc_bus_drv.sv
module mbc_bus_drv
   import mbc_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter bit IDLE_ADDR_DRIVE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  mbc_state_e        state_i,
   input  logic [ADDR_W-1:0] op_addr_i,
   input  logic              op_wr_i,
   input  logic              op_io_i,
   input  logic [DATA_W-1:0] op_wdata_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe_o,
   output logic [ADDR_W-DATA_W-1:0] a_hi_o,
   output logic              a_hi_oe_o,
   output logic              ale_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              iom_o,
   output logic              ctl_oe_o,
   output logic              hlda_o
);
   localparam int LO_W = DATA_W;

   logic idle_hi_oe;

   generate
      if (IDLE_ADDR_DRIVE) begin : g_idle_drive
         assign idle_hi_oe = 1'b1;
      end else begin : g_idle_float
         assign idle_hi_oe = 1'b0;
      end
   endgenerate

   always_comb begin
      ad_o      = op_addr_i[LO_W-1:0];
      ad_oe_o   = 1'b0;
      a_hi_o    = op_addr_i[ADDR_W-1:LO_W];
      a_hi_oe_o = 1'b1;
      ale_o     = 1'b0;
      rd_n_o    = 1'b1;
      wr_n_o    = 1'b1;
      iom_o     = op_io_i;
      ctl_oe_o  = 1'b1;
      hlda_o    = 1'b0;
      unique case (state_i)
         ST_RST: begin
            a_hi_oe_o = 1'b0;
            ctl_oe_o  = 1'b0;
            iom_o     = 1'b0;
         end
         ST_HOLD: begin
            a_hi_oe_o = 1'b0;
            ctl_oe_o  = 1'b0;
            hlda_o    = 1'b1;
         end
         ST_IDLE: a_hi_oe_o = idle_hi_oe;
         ST_T1: begin
            ale_o   = 1'b1;
            ad_oe_o = 1'b1;
         end
         ST_T2, ST_TW, ST_T3: begin
            if (op_wr_i) begin
               wr_n_o  = 1'b0;
               ad_o    = op_wdata_i;
               ad_oe_o = 1'b1;
            end else begin
               rd_n_o  = 1'b0;
            end
         end
         default: ;
      endcase
   end

   // R2
   ale_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ale_o |=> (!ale_o && (!rd_n_o || !wr_n_o)));

   // R11
   strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(!rd_n_o && !wr_n_o));

   // R3
   iom_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!rd_n_o || !wr_n_o) |-> ($stable(iom_o) && $stable(a_hi_o)));

   // R9
   hold_float_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      hlda_o |-> (!ad_oe_o && !a_hi_oe_o && !ctl_oe_o));
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
   import mbc_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter int RST_STAGES      = 2,
   parameter bit IDLE_ADDR_DRIVE = 1'b1
) (
   input  logic                     clk_i,
   input  logic                     rst_n_i,
   output logic                     rst_out_o,
   input  logic                     req_i,
   input  logic                     req_fetch_i,
   input  logic                     req_wr_i,
   input  logic                     req_io_i,
   input  logic [ADDR_W-1:0]        req_addr_i,
   input  logic [DATA_W-1:0]        req_wdata_i,
   output logic                     req_ack_o,
   output logic                     done_o,
   output logic [DATA_W-1:0]        rdata_o,
   output logic [DATA_W-1:0]        ad_o,
   output logic                     ad_oe_o,
   input  logic [DATA_W-1:0]        ad_i,
   output logic [ADDR_W-DATA_W-1:0] a_hi_o,
   output logic                     a_hi_oe_o,
   output logic                     ale_o,
   output logic                     rd_n_o,
   output logic                     wr_n_o,
   output logic                     iom_o,
   output logic                     ctl_oe_o,
   input  logic                     ready_i,
   input  logic                     hold_i,
   output logic                     hlda_o
);
   generate
      if (ADDR_W <= DATA_W) begin : g_bad_w
         $error("mbus_cycle_ctrl: ADDR_W must exceed DATA_W");
      end
   endgenerate

   logic              rst_int_n;
   logic [ADDR_W-1:0] pc;
   logic              fetch_step;
   mbc_state_e        state;
   logic [ADDR_W-1:0] op_addr;
   logic              op_wr;
   logic              op_io;
   logic [DATA_W-1:0] op_wdata;

   mbc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .rst_n_o (rst_int_n)
   );

   assign rst_out_o = !rst_int_n;

   mbc_fetch_ptr #(.ADDR_W(ADDR_W)) u_pc (
      .clk_i   (clk_i),
      .rst_n_i (rst_int_n),
      .step_i  (fetch_step),
      .pc_o    (pc)
   );

   mbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk_i        (clk_i),
      .rst_n_i      (rst_int_n),
      .req_i        (req_i),
      .req_fetch_i  (req_fetch_i),
      .req_wr_i     (req_wr_i),
      .req_io_i     (req_io_i),
      .req_addr_i   (req_addr_i),
      .req_wdata_i  (req_wdata_i),
      .pc_i         (pc),
      .ready_i      (ready_i),
      .hold_i       (hold_i),
      .ad_i         (ad_i),
      .state_o      (state),
      .op_addr_o    (op_addr),
      .op_wr_o      (op_wr),
      .op_io_o      (op_io),
      .op_wdata_o   (op_wdata),
      .req_ack_o    (req_ack_o),
      .fetch_step_o (fetch_step),
      .done_o       (done_o),
      .rdata_o      (rdata_o)
   );

   mbc_bus_drv #(
      .ADDR_W          (ADDR_W),
      .DATA_W          (DATA_W),
      .IDLE_ADDR_DRIVE (IDLE_ADDR_DRIVE)
   ) u_drv (
      .clk_i      (clk_i),
      .rst_n_i    (rst_int_n),
      .state_i    (state),
      .op_addr_i  (op_addr),
      .op_wr_i    (op_wr),
      .op_io_i    (op_io),
      .op_wdata_i (op_wdata),
      .ad_o       (ad_o),
      .ad_oe_o    (ad_oe_o),
      .a_hi_o     (a_hi_o),
      .a_hi_oe_o  (a_hi_oe_o),
      .ale_o      (ale_o),
      .rd_n_o     (rd_n_o),
      .wr_n_o     (wr_n_o),
      .iom_o      (iom_o),
      .ctl_oe_o   (ctl_oe_o),
      .hlda_o     (hlda_o)
   );

   // R10
   hlda_release_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
      (hlda_o && !hold_i) |=> (!hlda_o && ctl_oe_o && !ale_o));

   // R9
   hold_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
      hlda_o |-> !req_ack_o);
endmodule

// File: tb/mbus_cycle_ctrl_tb_top.sv
module mbus_cycle_ctrl_tb_top;
   logic clk_i = 1'b0;
   always #5 clk_i = ~clk_i;

   logic        rst_n_i, rst_out_o;
   logic        req_i, req_fetch_i, req_wr_i, req_io_i;
   logic [15:0] req_addr_i;
   logic [7:0]  req_wdata_i;
   logic        req_ack_o, done_o;
   logic [7:0]  rdata_o, ad_o, ad_i, a_hi_o;
   logic        ad_oe_o, a_hi_oe_o, ale_o, rd_n_o, wr_n_o, iom_o, ctl_oe_o;
   logic        ready_i, hold_i, hlda_o;

   mbus_cycle_ctrl dut_i (.*);

   typedef struct {
      logic [15:0] addr;
      logic        wr;
      logic        io;
      logic [7:0]  wd;
      int          waits;
   } exp_t;

   exp_t sb[$];
   exp_t cur;
   int   checks = 0, errors = 0;
   int   pc_model = 0;
   int   wcnt = 0;
   int   scnt = 0;
   bit   prev_stb = 0, prev_ale = 0, finished = 0;
   logic [7:0] lat_lo = 8'h00;

   function automatic logic [7:0] memfn(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // external address latch and slow memory model
   assign ad_i    = memfn({a_hi_o, lat_lo});
   assign ready_i = (wcnt == 0);

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic issue(input bit fetch, input bit wr, input bit io,
                        input logic [15:0] a, input logic [7:0] d, input int waits);
      exp_t e;
      e.addr  = fetch ? pc_model[15:0] : a;
      e.wr    = fetch ? 1'b0 : wr;
      e.io    = fetch ? 1'b0 : io;
      e.wd    = d;
      e.waits = waits;
      if (fetch) pc_model++;
      sb.push_back(e);
      @(negedge clk_i);
      req_fetch_i = fetch; req_wr_i = wr; req_io_i = io;
      req_addr_i = a; req_wdata_i = d; req_i = 1'b1;
      #1;
      while (!req_ack_o) begin @(negedge clk_i); #1; end
      @(posedge clk_i); #1;
      // R7: acknowledge lasts one clock even with req still high
      chk(!req_ack_o, "R7", "ack after accept", req_ack_o, 0);
      req_i = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk_i);
      @(negedge clk_i);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // monitor / scoreboard
   always @(negedge clk_i) begin
      automatic bit stb = !rd_n_o || !wr_n_o;
      if (rst_out_o) begin
         prev_stb = 0; prev_ale = 0; wcnt = 0;
      end else begin
         chk(!(!rd_n_o && !wr_n_o), "R11", "both strobes low", {rd_n_o, wr_n_o}, 2'b11);
         if (prev_ale)
            chk(!ale_o && stb, "R2", "ale one clock then strobe", {ale_o, stb}, 2'b01);
         if (ale_o) begin
            lat_lo = ad_o;
            if (sb.size() == 0) begin
               chk(0, "R7", "cycle with no request", 1, 0);
            end else begin
               cur  = sb[0];
               scnt = 0;
               wcnt = cur.waits;
               chk({a_hi_o, ad_o} == cur.addr && ad_oe_o && a_hi_oe_o && rd_n_o && wr_n_o,
                   "R2", "T1 address", {a_hi_o, ad_o}, cur.addr);
               chk(iom_o == cur.io, "R3", "iom in T1", iom_o, cur.io);
            end
         end
         if (stb) begin
            scnt++;
            if (prev_stb && wcnt > 0) wcnt--;
            chk(iom_o == cur.io && a_hi_o == cur.addr[15:8], "R3", "iom/high addr held",
                {iom_o, a_hi_o}, {cur.io, cur.addr[15:8]});
            if (cur.wr)
               chk(!wr_n_o && rd_n_o && ad_oe_o && ad_o == cur.wd, "R5", "write data phase",
                   ad_o, cur.wd);
            else
               chk(!rd_n_o && wr_n_o && !ad_oe_o, "R4", "read strobe phase",
                   {rd_n_o, wr_n_o, ad_oe_o}, 3'b010);
         end
         if (done_o) begin
            chk(scnt == 2 + cur.waits, "R6", "strobe clocks", scnt, 2 + cur.waits);
            if (!cur.wr)
               chk(rdata_o == memfn(cur.addr), "R4", "read data", rdata_o, memfn(cur.addr));
            else
               chk(1'b1, "R5", "write done", 1, 1);
            if (sb.size() != 0) void'(sb.pop_front());
         end
         prev_stb = stb;
         prev_ale = ale_o;
      end
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog run did not end actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n_i = 1'b0; req_i = 1'b0; req_fetch_i = 1'b0; req_wr_i = 1'b0;
      req_io_i = 1'b0; req_addr_i = '0; req_wdata_i = '0; hold_i = 1'b0;
      repeat (2) @(negedge clk_i);
      // R1: reset state
      chk(rst_out_o && !ad_oe_o && !a_hi_oe_o && !ctl_oe_o && !hlda_o, "R1", "reset pins",
          {rst_out_o, ad_oe_o, a_hi_oe_o, ctl_oe_o, hlda_o}, 5'b10000);
      rst_n_i = 1'b1;
      repeat (4) @(negedge clk_i);
      chk(!rst_out_o && ctl_oe_o, "R1", "reset released", {rst_out_o, ctl_oe_o}, 2'b01);

      // R8: fetches from the program counter, R1: first at 0
      issue(1, 0, 0, 16'h0000, 8'h00, 0);
      issue(1, 0, 0, 16'h0000, 8'h00, 1);
      issue(0, 0, 0, 16'h1234, 8'h00, 0);   // R4 memory read
      issue(0, 1, 1, 16'h00A5, 8'h3C, 2);   // R5/R3 I/O write
      issue(0, 1, 0, 16'hBEEF, 8'h81, 0);   // R5 memory write
      issue(0, 0, 1, 16'h0042, 8'h00, 3);   // R6 I/O read with waits
      issue(1, 1, 1, 16'hFFFF, 8'h77, 0);   // R8 flags and address ignored
      drain();

      // R9: hold while idle
      @(negedge clk_i); hold_i = 1'b1;
      @(negedge clk_i);
      chk(hlda_o && !ad_oe_o && !a_hi_oe_o && !ctl_oe_o, "R9", "hold floats bus",
          {hlda_o, ad_oe_o, a_hi_oe_o, ctl_oe_o}, 4'b1000);
      fork issue(0, 0, 0, 16'h4321, 8'h00, 0); join_none
      for (int i = 0; i < 3; i++) begin
         @(negedge clk_i); #2;
         chk(!req_ack_o && !ale_o, "R9", "no ack in hold", req_ack_o, 0);
      end
      hold_i = 1'b0;
      @(negedge clk_i); #2;
      chk(!hlda_o && ctl_oe_o && a_hi_oe_o && !ale_o, "R10", "bus back after hold",
          {hlda_o, ctl_oe_o, a_hi_oe_o, ale_o}, 4'b0110);
      drain();

      // R9: hold during a stretched cycle
      fork issue(0, 0, 0, 16'h0777, 8'h00, 4); join_none
      @(negedge clk_i);
      while (!ale_o) @(negedge clk_i);
      hold_i = 1'b1;
      @(negedge clk_i);
      while (!done_o) begin
         chk(!hlda_o, "R9", "hlda during cycle", hlda_o, 0);
         @(negedge clk_i);
      end
      chk(!hlda_o, "R9", "hlda at done", hlda_o, 0);
      @(negedge clk_i);
      chk(hlda_o && !ctl_oe_o, "R9", "hlda after cycle", hlda_o, 1);
      hold_i = 1'b0;
      @(negedge clk_i);
      chk(!hlda_o && ctl_oe_o, "R10", "hlda drop", hlda_o, 0);
      drain();

      // R1: reset in mid-cycle
      fork issue(0, 1, 1, 16'h5566, 8'hC3, 5); join_none
      @(negedge clk_i);
      while (!ale_o) @(negedge clk_i);
      @(negedge clk_i);
      rst_n_i = 1'b0;
      #1;
      chk(rst_out_o && !ad_oe_o && !a_hi_oe_o && !ctl_oe_o, "R1", "reset floats mid-cycle",
          {rst_out_o, ad_oe_o, a_hi_oe_o, ctl_oe_o}, 4'b1000);
      sb.delete();
      pc_model = 0;
      repeat (2) @(negedge clk_i);
      rst_n_i = 1'b1;
      repeat (4) @(negedge clk_i);
      issue(1, 0, 0, 16'h9999, 8'h00, 0);   // R1 program counter cleared
      drain();

      finished = 1;
      summary();
      $finish;
   end
endmodule